// File: doc/BRIEF.md
# Processor I/O Port with Memory Bank Control

This block is an 8-bit bidirectional port that sits inside a processor's address space at the two lowest addresses. Location $0000 holds a direction register and location $0001 holds a data latch. Each bit of the port can be an output or an input on its own. An output bit drives its pin from the data latch. An input bit follows its external pin, and reads as 1 when nothing drives that pin, as if a pull-up resistor were present.

The low six bits of the effective port value also control the memory map and the tape interface. Bit 0 enables the low BASIC ROM and bit 1 enables the high kernel ROM. Bit 2 selects I/O (1) or character ROM (0) in the $D000 window. Bit 3 is the tape write data, bit 4 is the tape switch sense input and bit 5 is tape motor control. The rest of the system decoder uses these select outputs directly.

Reads are registered. A read strobe to one of the two port addresses loads `rdata` at that clock edge, and `rdata` keeps its value until the next such read.

Top module: `cpuport_bank`

## Requirements
- R1: Once reset is released, the direction register reads $2F and the data latch is $00, so `pin_oe` is $2F and `pin_out` is $00.
- R2: A write strobe to address $0000 loads `wdata` into the direction register, and `pin_oe` follows it from the next edge. A direction bit of 1 means output.
- R3: A write strobe to address $0001 loads the data latch, and `pin_out` equals the latch for every bit, whatever the direction.
- R4: A read of $0001 returns the latch bit for output bits and the live pin level for input bits. The live level is `pin_in` where `pin_ext_oe` is 1.
- R5: A read of $0000 returns the direction register. `rdata` is loaded at the edge that samples `rd_en`, and it holds its value when there is no read to a port address.
- R6: Writes and reads to any 16-bit address other than $0000 and $0001 leave the registers and `rdata` unchanged.
- R7: `rom_lo_en` equals effective bit 0 and `rom_hi_en` equals effective bit 1.
- R8: `io_vis` equals effective bit 2: 1 selects I/O and 0 selects character ROM.
- R9: `tape_dout` equals effective bit 3, `tape_sense` equals effective bit 4 and `tape_motor` equals effective bit 5. Bit 4 is an input after reset.
- R10: With direction $2F, writing $37 to the latch sets all three bank selects to 1. Writing $34 clears both ROM enables and keeps `io_vis` at 1.
- R11: An input bit whose pin is not driven (`pin_ext_oe` bit 0) counts as 1, both in the read value and in the bank decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| pin_in | input | 8 | External pin levels |
| pin_ext_oe | input | 8 | Per pin, 1 when an external source drives the pin |
| rdata | output | 8 | Registered read data |
| pin_out | output | 8 | Pin drive values from the data latch |
| pin_oe | output | 8 | Per-pin output enables, equal to the direction register |
| rom_lo_en | output | 1 | Low BASIC ROM enable |
| rom_hi_en | output | 1 | High kernel ROM enable |
| io_vis | output | 1 | 1 maps I/O at $D000, 0 maps character ROM there |
| tape_dout | output | 1 | Tape write data |
| tape_sense | output | 1 | Tape switch sense level |
| tape_motor | output | 1 | Tape motor control |

## Verification
The hardest case to reach is a mixed port, where some bits come from the latch, some from a driven pin and some from an undriven pin that reads as pulled up. In that case the read value and the bank selects must take every bit from the correct source at once. The stimulus reaches it in three steps. It sets a partial direction mask, writes a latch value that is the opposite of the pin levels, and then drives only part of the input pins externally. Every bit whose source is wrong then shows up as an inverted bit.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;
  localparam int PORT_W = 8;
  localparam int BUS_AW = 16;

  // bit positions of the bank and tape controls
  localparam int B_ROM_LO = 0;
  localparam int B_ROM_HI = 1;
  localparam int B_IO_VIS = 2;
  localparam int B_T_DOUT = 3;
  localparam int B_T_SNS  = 4;
  localparam int B_T_MOT  = 5;
  localparam int CTRL_W   = 6;

  typedef struct packed {
    logic tape_motor;
    logic tape_sense;
    logic tape_dout;
    logic io_vis;
    logic rom_hi_en;
    logic rom_lo_en;
  } bank_sel_t;
endpackage

// File: rtl/cpuport_rstsync.sv
module cpuport_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cpuport_regs.sv
module cpuport_regs #(
  parameter int          W       = 8,
  parameter int          AW      = 16,
  parameter logic [W-1:0] DIR_RST = 8'h2F,
  parameter logic [W-1:0] DAT_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          wr_en,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q
);
  localparam logic [AW-1:0] A_DIR = AW'(0);
  localparam logic [AW-1:0] A_DAT = AW'(1);

  logic          dir_we;
  logic          dat_we;
  logic [W-1:0]  dir_d;
  logic [W-1:0]  dat_d;

  always_comb begin
    dir_we = wr_en && (addr == A_DIR);
    dat_we = wr_en && (addr == A_DAT);
    dir_d  = dir_we ? wdata : dir_q;
    dat_d  = dat_we ? wdata : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
      dat_q <= DAT_RST;
    end else begin
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end

  // R2: a direction write lands in the register
  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (dir_q == $past(wdata)));
  // R6: without a write to the port, both registers hold
  p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_DIR || addr == A_DAT)) |=> ($stable(dir_q) && $stable(dat_q)));
endmodule

// File: rtl/cpuport_pad.sv
module cpuport_pad #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] dat_q,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pin_ext_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] eff
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic level;
    always_comb begin
      level      = pin_ext_oe[i] ? pin_in[i] : 1'b1;
      pin_out[i] = dat_q[i];
      pin_oe[i]  = dir_q[i];
      eff[i]     = dir_q[i] ? dat_q[i] : level;
    end
  end
endmodule

// File: rtl/cpuport_bankdec.sv
module cpuport_bankdec
  import cpuport_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output bank_sel_t         sel
);
  always_comb begin
    sel.rom_lo_en  = ctrl[B_ROM_LO];
    sel.rom_hi_en  = ctrl[B_ROM_HI];
    sel.io_vis     = ctrl[B_IO_VIS];
    sel.tape_dout  = ctrl[B_T_DOUT];
    sel.tape_sense = ctrl[B_T_SNS];
    sel.tape_motor = ctrl[B_T_MOT];
  end
endmodule

// File: rtl/cpuport_bank.sv
module cpuport_bank
  import cpuport_pkg::*;
#(
  parameter int                W       = PORT_W,
  parameter int                AW      = BUS_AW,
  parameter logic [PORT_W-1:0] DIR_RST = 8'h2F,
  parameter logic [PORT_W-1:0] DAT_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  pin_ext_oe,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          rom_lo_en,
  output logic          rom_hi_en,
  output logic          io_vis,
  output logic          tape_dout,
  output logic          tape_sense,
  output logic          tape_motor
);
  localparam logic [AW-1:0] A_DIR = AW'(0);
  localparam logic [AW-1:0] A_DAT = AW'(1);

  logic         srst_n;
  logic [W-1:0] dir_q;
  logic [W-1:0] dat_q;
  logic [W-1:0] eff;
  logic [W-1:0] rdata_d;
  bank_sel_t    sel;

  cpuport_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  cpuport_regs #(.W(W), .AW(AW), .DIR_RST(DIR_RST), .DAT_RST(DAT_RST)) u_regs (
    .clk(clk), .rst_n(srst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .dir_q(dir_q), .dat_q(dat_q)
  );

  cpuport_pad #(.W(W)) u_pad (
    .dir_q(dir_q), .dat_q(dat_q), .pin_in(pin_in), .pin_ext_oe(pin_ext_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .eff(eff)
  );

  cpuport_bankdec u_dec (
    .ctrl(eff[CTRL_W-1:0]), .sel(sel)
  );

  always_comb begin
    rom_lo_en  = sel.rom_lo_en;
    rom_hi_en  = sel.rom_hi_en;
    io_vis     = sel.io_vis;
    tape_dout  = sel.tape_dout;
    tape_sense = sel.tape_sense;
    tape_motor = sel.tape_motor;
  end

  // read path: next-state, then register
  always_comb begin
    rdata_d = rdata;
    if (rd_en && addr == A_DIR) rdata_d = dir_q;
    else if (rd_en && addr == A_DAT) rdata_d = eff;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdata <= '0;
    else         rdata <= rdata_d;
  end

  // R5: a direction read returns the direction register
  p_rd_dir_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && addr == A_DIR) |=> (rdata == $past(pin_oe)));
  // R6: no port read leaves rdata alone
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !(rd_en && (addr == A_DIR || addr == A_DAT)) |=> $stable(rdata));
  // R7: an output bit 0 drives the low ROM enable from the latch
  p_lo_follows_latch_r7: assert property (@(posedge clk) disable iff (!srst_n)
    pin_oe[B_ROM_LO] |-> (rom_lo_en == pin_out[B_ROM_LO]));
  // R11: an undriven input bit 2 pulls the I/O select high
  p_io_pullup_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!pin_oe[B_IO_VIS] && !pin_ext_oe[B_IO_VIS]) |-> io_vis);
  // R9: a driven input bit 4 shows its pin level on the sense output
  p_sense_pin_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (!pin_oe[B_T_SNS] && pin_ext_oe[B_T_SNS]) |-> (tape_sense == pin_in[B_T_SNS]));
endmodule

// File: tb/cpuport_bank_bench.sv
module cpuport_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        wr_en;
  logic        rd_en;
  logic [7:0]  pin_in;
  logic [7:0]  pin_ext_oe;
  logic [7:0]  rdata;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic        rom_lo_en, rom_hi_en, io_vis, tape_dout, tape_sense, tape_motor;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cpuport_bank u_cpuport_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .pin_in(pin_in), .pin_ext_oe(pin_ext_oe), .rdata(rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .rom_lo_en(rom_lo_en),
    .rom_hi_en(rom_hi_en), .io_vis(io_vis), .tape_dout(tape_dout),
    .tape_sense(tape_sense), .tape_motor(tape_motor)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // effective value from the requirements: latch for outputs, pin or pull-up for inputs
  function automatic logic [7:0] model_eff(logic [7:0] d, logic [7:0] l,
                                           logic [7:0] p, logic [7:0] e);
    logic [7:0] lvl;
    lvl = (p & e) | ~e;
    return (d & l) | (~d & lvl);
  endfunction

  function automatic logic [7:0] sel_vec();
    return {2'b00, tape_motor, tape_sense, tape_dout, io_vis, rom_hi_en, rom_lo_en};
  endfunction

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    bus_rd(16'h0000);
    chk("R1 dir read", rdata, 8'h2F);
    chk("R1 pin_oe", pin_oe, 8'h2F);
    chk("R1 pin_out", pin_out, 8'h00);
    bus_rd(16'h0001);
    chk("R4 reset port read", rdata, model_eff(8'h2F, 8'h00, pin_in, pin_ext_oe));
    chk("R9 sense is input after reset", {7'd0, pin_oe[4]}, 8'h00);
  endtask

  task automatic t_all_inputs_pullup;
    bus_wr(16'h0000, 8'h00);
    chk("R2 pin_oe after dir write", pin_oe, 8'h00);
    chk("R11 undriven selects", sel_vec(), 8'h3F);
    bus_rd(16'h0001);
    chk("R11 undriven read", rdata, 8'hFF);
  endtask

  task automatic t_driven_inputs;
    @(negedge clk);
    pin_ext_oe = 8'hFF; pin_in = 8'hA5;
    #1;
    chk("R7 R8 R9 selects from pins", sel_vec(), 8'h25);
    bus_rd(16'h0001);
    chk("R4 driven input read", rdata, 8'hA5);
    @(negedge clk);
    pin_ext_oe = 8'h00;
  endtask

  task automatic t_bank_maps;
    bus_wr(16'h0000, 8'h2F);
    bus_wr(16'h0001, 8'h37);
    chk("R3 pin_out 37", pin_out, 8'h37);
    chk("R10 normal map", {5'd0, io_vis, rom_hi_en, rom_lo_en}, 8'h07);
    bus_rd(16'h0001);
    chk("R4 read with 37", rdata, model_eff(8'h2F, 8'h37, 8'h00, 8'h00));
    bus_wr(16'h0001, 8'h34);
    chk("R10 ram map", {5'd0, io_vis, rom_hi_en, rom_lo_en}, 8'h04);
    bus_wr(16'h0001, 8'h28);
    chk("R9 tape out and motor", {6'd0, tape_motor, tape_dout}, 8'h03);
    chk("R8 char rom selected", {7'd0, io_vis}, 8'h00);
  endtask

  task automatic t_mixed;
    bus_wr(16'h0000, 8'h0F);
    bus_wr(16'h0001, 8'hF0);
    @(negedge clk);
    pin_ext_oe = 8'h30; pin_in = 8'h10;
    #1;
    chk("R3 latch on input bits", pin_out, 8'hF0);
    chk("R9 mixed sense and motor", {6'd0, tape_motor, tape_sense}, 8'h01);
    chk("R7 mixed rom enables", {6'd0, rom_hi_en, rom_lo_en}, 8'h00);
    bus_rd(16'h0001);
    chk("R4 R11 mixed read", rdata, 8'hD0);
    @(negedge clk);
    pin_ext_oe = 8'h00;
  endtask

  task automatic t_other_addr;
    bus_wr(16'h0000, 8'h2F);
    bus_wr(16'h0001, 8'h37);
    bus_rd(16'h0000);
    bus_wr(16'h0100, 8'h00);
    bus_wr(16'h0101, 8'h00);
    bus_wr(16'hFF01, 8'h00);
    chk("R6 dir unchanged", pin_oe, 8'h2F);
    chk("R6 latch unchanged", pin_out, 8'h37);
    bus_rd(16'h0002);
    chk("R6 rdata held after foreign read", rdata, 8'h2F);
    @(negedge clk);
    pin_ext_oe = 8'hFF; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    chk("R5 rdata holds without read", rdata, 8'h2F);
    pin_ext_oe = 8'h00;
  endtask

  task automatic t_read_timing;
    @(negedge clk);
    addr = 16'h0001; rd_en = 1'b1;
    #1;
    chk("R5 rdata not yet loaded", rdata, 8'h2F);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 rdata loaded one edge later", rdata, model_eff(8'h2F, 8'h37, 8'h00, 8'h00));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
    pin_in = 8'h00; pin_ext_oe = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_all_inputs_pullup;
    t_driven_inputs;
    t_bank_maps;
    t_mixed;
    t_other_addr;
    t_read_timing;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule